// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre-Sample Voting

This block receives asynchronous serial frames from a line that has already been synchronised to the local clock. An external baud generator supplies a one-cycle `tick` enable at the oversampling rate. `dbl_speed` selects the oversampling ratio: 16 ticks per bit, or 8 ticks per bit for double speed. Idle is high. While idle, the receiver hunts for a low sample. It then times each bit from that sample and decides the level of the bit with a two-of-three vote over the samples at the middle of the bit.

Each frame carries a start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit and a stop bit. When the stop bit has been voted, the byte, a frame error flag and a parity error flag are registered and a one-cycle valid strobe is raised. The receiver is ready for a new start bit as soon as the stop bit's last voting sample has been taken, so a transmitter whose clock runs slightly fast is still received.

Top module: `uart_vote_rx`

## Requirements
- R1: While `rst` is high and after it is released, `rx_valid`, `rx_data`, `frame_err` and `parity_err` are all zero until a frame completes.
- R2: With `dbl_speed`=0 a bit lasts 16 ticks, counted from the first low idle sample as sample 1. The bit value is voted from samples 8, 9 and 10. Samples 1–7 and 11–16 have no effect.
- R3: With `dbl_speed`=1 a bit lasts 8 ticks and is voted from samples 4, 5 and 6. Samples 1–3, 7 and 8 have no effect.
- R4: A voted bit is 1 when at least two of its three centre samples are high, and 0 otherwise. The same vote decides the start, data, parity and stop bits, so one disturbed centre sample never changes a result.
- R5: `data_bits_sel` selects 5 + `data_bits_sel` data bits (0→5 … 3→8). Data is received least significant bit first into `rx_data`, and the bits above the frame width read 0.
- R6: With `parity_en`=1 a parity bit follows the data. `parity_odd`=0 expects the XOR of the data and parity bits to be 0, and `parity_odd`=1 expects it to be 1. `parity_err` is 1 for a mismatch. With `parity_en`=0 no parity bit is received and `parity_err` is 0.
- R7: `frame_err` is 1 exactly when the voted stop bit is 0.
- R8: `rx_valid` is high for one clock, in the cycle after the tick that carries the stop bit's last voting sample. `rx_data`, `frame_err` and `parity_err` change only together with `rx_valid` and then hold.
- R9: In normal mode, a low sample on the tick right after the stop bit's last voting sample (stop sample 11) is taken as a new start. In double speed mode the receiver skips one tick (stop sample 7), and the earliest new start sample is stop sample 8.
- R10: If the start bit's centre vote is 1, the event is discarded without a strobe and hunting resumes.
- R11: Only the first stop bit is sampled. Further high bit periods after it produce no strobe and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Synchronised serial line, idle high |
| tick | input | 1 | Oversampling enable, one cycle per sample |
| dbl_speed | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| data_bits_sel | input | SELW (2) | Data bits per frame minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| rx_data | output | DMAX (8) | Received data, right aligned |
| rx_valid | output | 1 | One-cycle strobe per completed frame |
| frame_err | output | 1 | Voted stop bit was 0 |
| parity_err | output | 1 | Parity mismatch in the last frame |

## Verification
If the sample position counter is off by even one tick, the vote window slides. Sweeps that disturb individual samples just inside and just outside the centre then show wrong data or error flags on the next strobe. A wrong frame-length or parity state shows within one frame as a misaligned `rx_data`, a wrong `parity_err`, or a strobe that comes one bit late and fails the cycle-exact timing check. A faulty return to hunting shows at the following frame: a start that comes one tick early or late either produces a frame that should not exist or loses one that should.

// File: rtl/uart_vote_pkg.sv
package uart_vote_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GAP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_vote_sampler.sv
module uart_vote_sampler #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic dbl,
  input  logic rxd,
  input  logic load,
  input  logic run,
  output logic vote_now,
  output logic vote_val,
  output logic bit_end
);
  import uart_vote_pkg::*;

  localparam int PW = $clog2(OVS + 1);

  logic [PW-1:0] pos;
  logic [PW-1:0] cur;
  logic [PW-1:0] n_lim;
  logic [PW-1:0] ctr;
  logic          s_early;
  logic          s_mid;
  logic          active;

  assign n_lim  = dbl ? PW'(OVS / 2) : PW'(OVS);
  assign ctr    = dbl ? PW'(OVS / 4 + 1) : PW'(OVS / 2 + 1);
  assign active = tick & (load | run);

  always_comb begin
    if (load || pos == n_lim) cur = PW'(1);
    else                      cur = pos + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (active) begin
      pos <= cur;
      if (cur == ctr - PW'(1)) s_early <= rxd;
      if (cur == ctr)          s_mid   <= rxd;
    end
  end

  assign vote_now = tick & run & (cur == ctr + PW'(1));
  assign vote_val = maj3(s_early, s_mid, rxd);
  assign bit_end  = tick & run & (pos == n_lim);

endmodule

// File: rtl/uart_vote_assembler.sv
module uart_vote_assembler #(
  parameter int DMAX = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic                           shift_en,
  input  logic                           bit_in,
  input  logic [$clog2(DMAX+1)-1:0]      nbits,
  output logic [DMAX-1:0]                word,
  output logic                           xsum
);
  localparam int NW = $clog2(DMAX + 1);

  logic [DMAX-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh   <= '0;
      xsum <= 1'b0;
    end else if (shift_en) begin
      sh   <= {bit_in, sh[DMAX-1:1]};
      xsum <= xsum ^ bit_in;
    end
  end

  assign word = sh >> (NW'(DMAX) - nbits);

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int OVS  = 16,
  parameter int DMAX = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rxd,
  input  logic            tick,
  input  logic            dbl_speed,
  input  logic [SELW-1:0] data_bits_sel,
  input  logic            parity_en,
  input  logic            parity_odd,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_valid,
  output logic            frame_err,
  output logic            parity_err
);
  import uart_vote_pkg::*;

  localparam int NW       = $clog2(DMAX + 1);
  localparam int MIN_BITS = DMAX - (1 << SELW) + 1;

  rx_state_t       state;
  logic [NW-1:0]   bit_cnt;
  logic [NW-1:0]   nbits;
  logic            par_bit;
  logic            load;
  logic            run;
  logic            vote_now;
  logic            vote_val;
  logic            bit_end;
  logic [DMAX-1:0] word;
  logic            xsum;

  assign nbits = NW'(MIN_BITS) + NW'(data_bits_sel);
  assign load  = (state == ST_IDLE) & tick & ~rxd;
  assign run   = (state == ST_START) | (state == ST_DATA) |
                 (state == ST_PAR)   | (state == ST_STOP);

  uart_vote_sampler #(.OVS(OVS)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .dbl      (dbl_speed),
    .rxd      (rxd),
    .load     (load),
    .run      (run),
    .vote_now (vote_now),
    .vote_val (vote_val),
    .bit_end  (bit_end)
  );

  uart_vote_assembler #(.DMAX(DMAX)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .clear    (load),
    .shift_en (vote_now & (state == ST_DATA)),
    .bit_in   (vote_val),
    .nbits    (nbits),
    .word     (word),
    .xsum     (xsum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      par_bit    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load) begin
            state   <= ST_START;
            bit_cnt <= '0;
          end
        end
        ST_START: begin
          if (vote_now && vote_val) state <= ST_IDLE;
          else if (bit_end)         state <= ST_DATA;
        end
        ST_DATA: begin
          if (vote_now) bit_cnt <= bit_cnt + NW'(1);
          if (bit_end && bit_cnt == nbits)
            state <= parity_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: begin
          if (vote_now) par_bit <= vote_val;
          if (bit_end)  state   <= ST_STOP;
        end
        ST_STOP: begin
          if (vote_now) begin
            rx_valid   <= 1'b1;
            rx_data    <= word;
            frame_err  <= ~vote_val;
            parity_err <= parity_en & ((xsum ^ par_bit) != parity_odd);
            state      <= dbl_speed ? ST_GAP : ST_IDLE;
          end
        end
        ST_GAP: begin
          if (tick) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
  parameter int DMAX = 8,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic [SELW-1:0] data_bits_sel,
  input logic            parity_en,
  input logic [DMAX-1:0] rx_data,
  input logic            rx_valid,
  input logic            frame_err,
  input logic            parity_err
);

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(parity_err)));

  assert_valid_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(tick));

  assert_no_parity_err_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !parity_en) |-> !parity_err);

  assert_short_word_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && data_bits_sel == '0) |-> (rx_data >> (DMAX - (1 << SELW) + 1)) == '0);

endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DMAX(DMAX), .SELW(SELW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick          (tick),
  .data_bits_sel (data_bits_sel),
  .parity_en     (parity_en),
  .rx_data       (rx_data),
  .rx_valid      (rx_valid),
  .frame_err     (frame_err),
  .parity_err    (parity_err)
);

// File: tb/tb_uart_vote_rx.sv
`timescale 1ns/1ps
module tb_uart_vote_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       dbl = 1'b0;
  logic [1:0] sel = 2'd3;
  logic       pen = 1'b0;
  logic       podd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, parity_err;

  int total = 0, bad = 0, cyc = 0;
  int vcount = 0, vcyc = 0, stop_cyc = -1;
  logic [7:0] vdata = '0;
  logic vfe = 1'b0, vpe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_vote_rx dut (
    .clk(clk), .rst(rst), .rxd(rxd), .tick(tick), .dbl_speed(dbl),
    .data_bits_sel(sel), .parity_en(pen), .parity_odd(podd),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (!rst && rx_valid) begin
      vcount = vcount + 1;
      vdata  = rx_data;
      vfe    = frame_err;
      vpe    = parity_err;
      vcyc   = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic put(input logic v, input bit mark);
    @(negedge clk);
    rxd  = v;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (mark) stop_cyc = cyc;
  endtask

  task automatic idle_samples(input int k);
    for (int i = 0; i < k; i++) put(1'b1, 1'b0);
  endtask

  function automatic int nper();
    return dbl ? 8 : 16;
  endfunction

  function automatic int cpos();
    return dbl ? 5 : 9;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit flip_p, input bit bad_stop,
                            input int cbit, input logic [16:0] cmask, input int stop_len);
    logic [11:0] fb;
    int nb, last, lim;
    logic v;
    nb = 5 + int'(sel);
    fb = '1;
    fb[0] = 1'b0;
    for (int i = 0; i < nb; i++) fb[1+i] = d[i];
    last = 1 + nb;
    if (pen) begin
      fb[last] = (^(d & 8'((1 << nb) - 1))) ^ podd ^ flip_p;
      last++;
    end
    fb[last] = 1'b1;
    for (int b = 0; b <= last; b++) begin
      lim = (b == last) ? stop_len : nper();
      for (int s = 1; s <= lim; s++) begin
        v = fb[b];
        if (b == cbit && cmask[s]) v = ~v;
        if (b == last && bad_stop) v = (s <= cpos() + 1) ? 1'b0 : 1'b1;
        put(v, (b == last) && (s == cpos() + 1));
      end
    end
  endtask

  task automatic frame_check(input logic [7:0] d, input bit flip_p, input bit bad_stop,
                             input int cbit, input logic [16:0] cmask,
                             input logic [7:0] exp_d, input bit exp_fe, input bit exp_pe,
                             input string rq);
    int c0;
    c0 = vcount;
    send_frame(d, flip_p, bad_stop, cbit, cmask, nper());
    idle_samples(nper());
    chk(vcount == c0 + 1, "R11 one strobe per frame", vcount - c0, 1);
    chk(vdata == exp_d, rq, int'(vdata), int'(exp_d));
    chk(vfe == exp_fe, "R7 frame_err", int'(vfe), int'(exp_fe));
    chk(vpe == exp_pe, "R6 parity_err", int'(vpe), int'(exp_pe));
    chk(vcyc == stop_cyc, "R8 strobe cycle", vcyc, stop_cyc);
    @(negedge clk);
    chk(rx_data == exp_d, "R8 data held", int'(rx_data), int'(exp_d));
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, nb;
    logic [7:0] d, m;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(rx_valid == 1'b0 && rx_data == 8'h00 && !frame_err && !parity_err,
        "R1 reset outputs", int'(rx_data), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_data == 8'h00, "R1 after release", int'(rx_valid), 0);
    idle_samples(4);

    // R2 R3 R5 R6: sweep speed, width, parity mode and data
    for (int sp = 0; sp < 2; sp++) begin
      for (int w = 0; w < 4; w++) begin
        for (int pm = 0; pm < 3; pm++) begin
          for (int k = 0; k < 6; k++) begin
            dbl  = sp[0];
            sel  = w[1:0];
            pen  = (pm != 0);
            podd = (pm == 2);
            nb   = 5 + w;
            d    = 8'(k * 73 + nb * 11 + pm * 29 + sp * 5);
            m    = 8'((1 << nb) - 1);
            frame_check(d, pen && k == 3, 1'b0, -1, '0, d & m, 1'b0, pen && k == 3,
                        sp ? "R3 R5 data" : "R2 R5 data");
          end
        end
      end
    end

    // R4 R2: majority and sample position, normal speed
    dbl = 1'b0; sel = 2'd3; pen = 1'b1; podd = 1'b0;
    frame_check(8'hA5, 1'b0, 1'b0, 4, 17'(1 << 9), 8'hA5, 1'b0, 1'b0, "R4 one centre sample");
    frame_check(8'hA5, 1'b0, 1'b0, 4, 17'((1 << 8) | (1 << 10)), 8'hAD, 1'b0, 1'b1,
                "R4 two centre samples");
    frame_check(8'hA5, 1'b0, 1'b0, 4, 17'h1FFFE & ~17'((1 << 8) | (1 << 9) | (1 << 10)),
                8'hA5, 1'b0, 1'b0, "R2 outside samples");
    // R3: double speed positions
    dbl = 1'b1;
    frame_check(8'hA5, 1'b0, 1'b0, 4, 17'h18E, 8'hA5, 1'b0, 1'b0, "R3 outside samples");
    frame_check(8'hA5, 1'b0, 1'b0, 4, 17'((1 << 4) | (1 << 6)), 8'hAD, 1'b0, 1'b1,
                "R3 two centre samples");

    // R7 and R4 on the stop bit
    pen = 1'b0;
    frame_check(8'h3C, 1'b0, 1'b1, -1, '0, 8'h3C, 1'b1, 1'b0, "R7 double bad stop");
    dbl = 1'b0;
    frame_check(8'h3C, 1'b0, 1'b1, -1, '0, 8'h3C, 1'b1, 1'b0, "R7 normal bad stop");
    frame_check(8'hC3, 1'b0, 1'b0, 9, 17'(1 << 9), 8'hC3, 1'b0, 1'b0, "R4 stop one low");

    // R9: back-to-back frames with early restart, normal speed
    c0 = vcount;
    send_frame(8'h12, 1'b0, 1'b0, -1, '0, 10);
    chk(vcount == c0 + 1 && vdata == 8'h12, "R9 normal first", int'(vdata), 8'h12);
    send_frame(8'h34, 1'b0, 1'b0, -1, '0, 16);
    idle_samples(16);
    chk(vcount == c0 + 2 && vdata == 8'h34, "R9 normal second", int'(vdata), 8'h34);
    // R9: start low exactly from stop sample 11 on for 9 samples is accepted
    c0 = vcount;
    send_frame(8'h00, 1'b0, 1'b0, -1, '0, 10);
    for (int i = 0; i < 9; i++) put(1'b0, 1'b0);
    idle_samples(7 + 9 * 16);
    chk(vcount == c0 + 2, "R9 normal earliest start", vcount - c0, 2);
    chk(vdata == 8'hFF && !vfe, "R9 normal earliest data", int'(vdata), 255);
    // R9: double speed back-to-back with one skipped tick
    dbl = 1'b1;
    c0 = vcount;
    send_frame(8'h56, 1'b0, 1'b0, -1, '0, 7);
    send_frame(8'h78, 1'b0, 1'b0, -1, '0, 8);
    idle_samples(8);
    chk(vcount == c0 + 2 && vdata == 8'h78, "R9 double back-to-back", int'(vdata), 8'h78);
    // R9: in double speed, stop sample 7 is skipped, so a 5-sample low is a glitch
    c0 = vcount;
    send_frame(8'h9A, 1'b0, 1'b0, -1, '0, 6);
    for (int i = 0; i < 5; i++) put(1'b0, 1'b0);
    idle_samples(3 + 10 * 8);
    chk(vcount == c0 + 1, "R9 double skipped sample", vcount - c0, 1);
    chk(rx_data == 8'h9A, "R9 double data kept", int'(rx_data), 8'h9A);

    // R10: start glitches
    dbl = 1'b0;
    c0 = vcount;
    for (int i = 0; i < 7; i++) put(1'b0, 1'b0);
    idle_samples(9 + 32);
    chk(vcount == c0, "R10 short low", vcount - c0, 0);
    for (int i = 0; i < 8; i++) put(1'b0, 1'b0);
    idle_samples(8 + 32);
    chk(vcount == c0, "R10 one centre low", vcount - c0, 0);
    chk(rx_data == 8'h9A, "R10 outputs unchanged", int'(rx_data), 8'h9A);
    frame_check(8'h6E, 1'b0, 1'b0, -1, '0, 8'h6E, 1'b0, 1'b0, "R10 frame after glitch");

    // R11: further high bit periods add nothing
    c0 = vcount;
    idle_samples(48);
    chk(vcount == c0 && rx_data == 8'h6E, "R11 extra stop bits", vcount - c0, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule